// File: doc/BRIEF.md
# Guarded Cell Framer with Header Rewrite

This block sits on a byte-wide stream of fixed 64-byte cells that arrive back to back, one byte per clock, with no outer transport framing around them. Each cell opens with a six-byte all-ones guard. A five-byte header comes next, in the standard user-network layout (GFC, VPI, VCI, PTI, CLP, HEC). A second all-ones guard of five bytes separates the header from the 48-byte payload. Boundary hunting is done upstream. The block only receives a one-cycle alignment pulse on the first byte of a cell, and from then on it counts byte positions by itself.

On the input side the block pulls the VPI/VCI out of each header and issues a one-cycle lookup request to an external route table. The stream passes through a fixed delay line of `DLY` cycles. This gives the route table time to reply before the header leaves the block. If a reply arrives in time, the outgoing header carries the new VPI/VCI, and the HEC byte is recomputed over the rewritten header. If no reply arrives in time, the header goes out untouched and a miss pulse is raised. Guards and payload are always copied unchanged. The output carries a byte-position count, a pulse on the first header byte, a pulse on the first payload byte, and a per-cell flag that reports a corrupted guard.

Top module: `cfr_framer`

## Requirements
- R1: After reset, and until the first aligned byte has crossed the delay line, `out_valid`, `out_hdr_start`, `out_pay_start`, `out_lkp_miss`, `out_guard_err` and `lkp_req` are all 0.
- R2: A byte sampled with `in_align` high is position 0, the first byte of the six-byte leading guard. Later bytes count up by one and wrap from 63 to 0. A new `in_align` restarts the count at 0 at any time. `out_pos` reports the position of the byte on `out_byte`.
- R3: Every byte sampled at a clock edge appears on `out_byte`, with `out_valid` high, exactly `DLY` edges later (`DLY` in 4..60).
- R4: `out_hdr_start` is high exactly when `out_pos` is 6 (the first header byte). `out_pay_start` is high exactly when `out_pos` is 16 (the first payload byte).
- R5: `lkp_req` pulses for one cycle after the edge that samples position 9 (the fourth header byte). With header bytes h0..h3, `lkp_vpi` = {h0[3:0], h1[7:4]} and `lkp_vci` = {h1[3:0], h2, h3[7:4]}.
- R6: A reply (`rsp_valid` high at an edge) is accepted for the pending cell if it is sampled at the first edge where `lkp_req` is high or at any of the following `DLY`-4 edges. If several replies fall in that window, the latest one is used.
- R7: When a reply was accepted, output header byte 0 is {original GFC nibble, new VPI[7:4]}, byte 1 is {new VPI[3:0], new VCI[15:12]}, byte 2 is new VCI[11:4], and byte 3 is {new VCI[3:0], original PTI/CLP nibble}. Guard and payload bytes always pass unchanged.
- R8: When a reply was accepted, the output HEC byte (position 10) is the CRC-8 of the four emitted header bytes, XORed with 0x55. The CRC uses polynomial x^8+x^2+x+1, initial value 0, and is computed MSB first.
- R9: With no accepted reply, all five header bytes pass unchanged and `out_lkp_miss` pulses together with `out_hdr_start`. A reply that arrives after the window changes neither that cell nor the next one.
- R10: `out_guard_err` pulses together with `out_pay_start` when any byte at positions 0-5 or 11-15 of that cell was not 0xFF. Position counting continues unchanged in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Incoming stream byte, one per clock |
| in_align | input | 1 | Marks the current byte as position 0 of a cell |
| lkp_req | output | 1 | One-cycle route lookup request |
| lkp_vpi | output | 8 | VPI extracted from the current header |
| lkp_vci | output | 16 | VCI extracted from the current header |
| rsp_valid | input | 1 | Lookup reply strobe |
| rsp_vpi | input | 8 | Replacement VPI |
| rsp_vci | input | 16 | Replacement VCI |
| out_valid | output | 1 | Output byte belongs to an aligned stream |
| out_byte | output | 8 | Outgoing byte |
| out_pos | output | 6 | Byte position of `out_byte` within its cell |
| out_hdr_start | output | 1 | First header byte on the output |
| out_pay_start | output | 1 | First payload byte on the output |
| out_lkp_miss | output | 1 | Header left unchanged because no reply arrived in time |
| out_guard_err | output | 1 | A guard byte of this cell was not all ones |

## Verification
The bench sends replies at the edge where the request is first sampled high, at the last edge of the acceptance window, one edge after the window closes, and not at all. A design whose window is off by one either rewrites a header it should leave alone or misses a reply it should have used. A late reply that leaks into the next cell shows up as a header rewritten with stale values. The bench also corrupts a leading-guard byte, an inner-guard byte and the very first byte of a cell. It realigns in the middle of a leading guard, so a design that mishandles the restart reports wrong positions or carries a stale guard error forward. Each rewritten HEC is checked against a CRC computed separately in the bench, which catches a wrong polynomial, a missing 0x55 offset, or a CRC taken over the original bytes instead of the emitted ones.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int CELL_BYTES = 64;
  localparam int POS_W      = $clog2(CELL_BYTES);
  localparam int BYTE_W     = 8;
  localparam int VPI_W      = 8;
  localparam int VCI_W      = 16;

  // byte positions inside one cell (wire order: guard, header, guard, payload)
  localparam logic [POS_W-1:0] P_LEAD_LAST = POS_W'(5);
  localparam logic [POS_W-1:0] P_HDR0      = POS_W'(6);
  localparam logic [POS_W-1:0] P_HDR1      = POS_W'(7);
  localparam logic [POS_W-1:0] P_HDR2      = POS_W'(8);
  localparam logic [POS_W-1:0] P_HDR3      = POS_W'(9);
  localparam logic [POS_W-1:0] P_HEC       = POS_W'(10);
  localparam logic [POS_W-1:0] P_GAP0      = POS_W'(11);
  localparam logic [POS_W-1:0] P_GAP_LAST  = POS_W'(15);
  localparam logic [POS_W-1:0] P_PAY0      = POS_W'(16);
  localparam logic [POS_W-1:0] P_FIRST     = '0;

  localparam logic [BYTE_W-1:0] GUARD_VAL = 8'hFF;
  localparam logic [BYTE_W-1:0] HEC_COSET = 8'h55;
  localparam logic [BYTE_W-1:0] CRC_POLY  = 8'h07;

  typedef struct packed {
    logic              lock;
    logic [POS_W-1:0]  pos;
    logic [BYTE_W-1:0] data;
  } slot_t;

  localparam int SLOT_W = $bits(slot_t);

  function automatic logic [BYTE_W-1:0] crc8_step(input logic [BYTE_W-1:0] crc,
                                                  input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] c;
    c = crc ^ d;
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[BYTE_W-1] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic is_guard(input logic [POS_W-1:0] p);
    return (p <= P_LEAD_LAST) || ((p >= P_GAP0) && (p <= P_GAP_LAST));
  endfunction
endpackage

// File: rtl/cfr_pos_track.sv
module cfr_pos_track
  import cfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_align,
  output logic [POS_W-1:0] pos_now,
  output logic             lock_now
);
  logic [POS_W-1:0] cnt;
  logic             locked;

  assign pos_now  = in_align ? P_FIRST : cnt;
  assign lock_now = in_align | locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else begin
      cnt <= pos_now + 1'b1;
      if (in_align) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/cfr_delay_ram.sv
module cfr_delay_ram #(
  parameter int DLY   = 12,
  parameter int WIDTH = 15,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_ok
);
  localparam int             AW       = $clog2(DEPTH);
  localparam logic [AW-1:0]  RD_OFS   = AW'(DLY - 1);
  localparam int             FW       = $clog2(DLY) + 1;
  localparam logic [FW-1:0]  FILL_MAX = FW'(DLY - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp;
  logic [FW-1:0]    fill;

  // plain dual-port pattern: one write port, one registered read port
  always_ff @(posedge clk) begin
    mem[wp] <= wr_data;
    rd_data <= mem[wp - RD_OFS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      fill  <= '0;
      rd_ok <= 1'b0;
    end else begin
      wp    <= wp + 1'b1;
      rd_ok <= (fill == FILL_MAX);
      if (fill != FILL_MAX) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/cfr_lookup_ctl.sv
module cfr_lookup_ctl
  import cfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [POS_W-1:0]  pos_now,
  input  logic              lock_now,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              rsp_valid,
  input  logic [VPI_W-1:0]  rsp_vpi,
  input  logic [VCI_W-1:0]  rsp_vci,
  input  logic              decide,
  output logic              lkp_req,
  output logic [VPI_W-1:0]  lkp_vpi,
  output logic [VCI_W-1:0]  lkp_vci,
  output logic              take,
  output logic [VPI_W-1:0]  take_vpi,
  output logic [VCI_W-1:0]  take_vci
);
  logic [BYTE_W-1:0] hb0, hb1, hb2;
  logic              waiting, pend, accept;
  logic [VPI_W-1:0]  pvpi;
  logic [VCI_W-1:0]  pvci;

  assign accept   = waiting & rsp_valid;
  assign take     = pend | accept;
  assign take_vpi = accept ? rsp_vpi : pvpi;
  assign take_vci = accept ? rsp_vci : pvci;

  always_ff @(posedge clk) begin
    if (lock_now) begin
      if (pos_now == P_HDR0) hb0 <= in_byte;
      if (pos_now == P_HDR1) hb1 <= in_byte;
      if (pos_now == P_HDR2) hb2 <= in_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lkp_req <= 1'b0;
      lkp_vpi <= '0;
      lkp_vci <= '0;
      waiting <= 1'b0;
      pend    <= 1'b0;
      pvpi    <= '0;
      pvci    <= '0;
    end else begin
      lkp_req <= 1'b0;
      if (accept) begin
        pend <= 1'b1;
        pvpi <= rsp_vpi;
        pvci <= rsp_vci;
      end
      if (decide) begin
        waiting <= 1'b0;
        pend    <= 1'b0;
      end
      if (lock_now && pos_now == P_HDR3) begin
        lkp_req <= 1'b1;
        lkp_vpi <= {hb0[3:0], hb1[7:4]};
        lkp_vci <= {hb1[3:0], hb2, in_byte[7:4]};
        waiting <= 1'b1;
        pend    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfr_hdr_rewrite.sv
module cfr_hdr_rewrite
  import cfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              s_lock,
  input  logic [POS_W-1:0]  s_pos,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              take,
  input  logic [VPI_W-1:0]  take_vpi,
  input  logic [VCI_W-1:0]  take_vci,
  output logic              decide,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic [POS_W-1:0]  out_pos,
  output logic              out_hdr_start,
  output logic              out_pay_start,
  output logic              out_lkp_miss,
  output logic              out_guard_err
);
  logic              rw;
  logic [VPI_W-1:0]  nvpi;
  logic [VCI_W-1:0]  nvci;
  logic [BYTE_W-1:0] crc, crc_nx, obyte;
  logic              bad;
  logic              eff_rw;
  logic [VPI_W-1:0]  eff_vpi;
  logic [VCI_W-1:0]  eff_vci;

  assign decide  = s_lock && (s_pos == P_HDR0);
  assign eff_rw  = decide ? take     : rw;
  assign eff_vpi = decide ? take_vpi : nvpi;
  assign eff_vci = decide ? take_vci : nvci;

  always_comb begin
    obyte  = s_data;
    crc_nx = crc;
    if (s_lock && eff_rw) begin
      unique case (s_pos)
        P_HDR0:  obyte = {s_data[7:4], eff_vpi[7:4]};
        P_HDR1:  obyte = {eff_vpi[3:0], eff_vci[15:12]};
        P_HDR2:  obyte = eff_vci[11:4];
        P_HDR3:  obyte = {eff_vci[3:0], s_data[3:0]};
        P_HEC:   obyte = crc ^ HEC_COSET;
        default: obyte = s_data;
      endcase
    end
    if (s_pos == P_HDR0) crc_nx = crc8_step('0, obyte);
    else if (s_pos >= P_HDR1 && s_pos <= P_HDR3) crc_nx = crc8_step(crc, obyte);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rw   <= 1'b0;
      nvpi <= '0;
      nvci <= '0;
      crc  <= '0;
      bad  <= 1'b0;
    end else if (s_lock) begin
      crc <= crc_nx;
      if (decide) begin
        rw   <= take;
        nvpi <= take_vpi;
        nvci <= take_vci;
      end
      if (s_pos == P_FIRST)    bad <= (s_data != GUARD_VAL);
      else if (is_guard(s_pos)) bad <= bad | (s_data != GUARD_VAL);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_byte      <= '0;
      out_pos       <= '0;
      out_hdr_start <= 1'b0;
      out_pay_start <= 1'b0;
      out_lkp_miss  <= 1'b0;
      out_guard_err <= 1'b0;
    end else begin
      out_valid     <= s_lock;
      out_byte      <= s_lock ? obyte : '0;
      out_pos       <= s_lock ? s_pos : '0;
      out_hdr_start <= decide;
      out_pay_start <= s_lock && (s_pos == P_PAY0);
      out_lkp_miss  <= decide && !take;
      out_guard_err <= s_lock && (s_pos == P_PAY0) && bad;
    end
  end
endmodule

// File: rtl/cfr_framer.sv
module cfr_framer
  import cfr_pkg::*;
#(
  parameter int DLY = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  in_byte,
  input  logic        in_align,
  output logic        lkp_req,
  output logic [7:0]  lkp_vpi,
  output logic [15:0] lkp_vci,
  input  logic        rsp_valid,
  input  logic [7:0]  rsp_vpi,
  input  logic [15:0] rsp_vci,
  output logic        out_valid,
  output logic [7:0]  out_byte,
  output logic [5:0]  out_pos,
  output logic        out_hdr_start,
  output logic        out_pay_start,
  output logic        out_lkp_miss,
  output logic        out_guard_err
);
  generate
    if (DLY < 4 || DLY > 60) begin : g_bad_dly
      $error("cfr_framer: DLY must lie in 4..60");
    end
  endgenerate

  logic [POS_W-1:0] pos_now;
  logic             lock_now;
  slot_t            wslot, rslot;
  logic             rd_ok, s_lock, decide, take;
  logic [VPI_W-1:0] take_vpi;
  logic [VCI_W-1:0] take_vci;

  cfr_pos_track u_pos (
    .clk(clk), .rst(rst), .in_align(in_align),
    .pos_now(pos_now), .lock_now(lock_now)
  );

  assign wslot = '{lock: lock_now, pos: pos_now, data: in_byte};

  cfr_delay_ram #(.DLY(DLY), .WIDTH(SLOT_W), .DEPTH(CELL_BYTES)) u_dly (
    .clk(clk), .rst(rst), .wr_data(wslot), .rd_data(rslot), .rd_ok(rd_ok)
  );

  assign s_lock = rd_ok & rslot.lock;

  cfr_lookup_ctl u_lkp (
    .clk(clk), .rst(rst), .pos_now(pos_now), .lock_now(lock_now),
    .in_byte(in_byte), .rsp_valid(rsp_valid), .rsp_vpi(rsp_vpi),
    .rsp_vci(rsp_vci), .decide(decide), .lkp_req(lkp_req),
    .lkp_vpi(lkp_vpi), .lkp_vci(lkp_vci), .take(take),
    .take_vpi(take_vpi), .take_vci(take_vci)
  );

  cfr_hdr_rewrite u_rw (
    .clk(clk), .rst(rst), .s_lock(s_lock), .s_pos(rslot.pos),
    .s_data(rslot.data), .take(take), .take_vpi(take_vpi),
    .take_vci(take_vci), .decide(decide), .out_valid(out_valid),
    .out_byte(out_byte), .out_pos(out_pos), .out_hdr_start(out_hdr_start),
    .out_pay_start(out_pay_start), .out_lkp_miss(out_lkp_miss),
    .out_guard_err(out_guard_err)
  );
endmodule

// File: rtl/cfr_framer_chk.sv
module cfr_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       lkp_req,
  input logic       out_valid,
  input logic [5:0] out_pos,
  input logic       out_hdr_start,
  input logic       out_pay_start,
  input logic       out_lkp_miss,
  input logic       out_guard_err
);
  a_r1_quiet_unlocked: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_hdr_start && !out_pay_start && !out_lkp_miss && !out_guard_err);

  a_r2_pos_step: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(out_valid) && out_pos != 6'd0 |-> out_pos == $past(out_pos) + 6'd1);

  a_r4_hdr_at_six: assert property (@(posedge clk) disable iff (rst)
    out_hdr_start |-> out_valid && out_pos == 6'd6);

  a_r4_pay_at_sixteen: assert property (@(posedge clk) disable iff (rst)
    out_pay_start |-> out_valid && out_pos == 6'd16);

  a_r5_req_single: assert property (@(posedge clk) disable iff (rst)
    lkp_req |=> !lkp_req);

  a_r9_miss_with_hdr: assert property (@(posedge clk) disable iff (rst)
    out_lkp_miss |-> out_hdr_start);

  a_r10_gerr_with_pay: assert property (@(posedge clk) disable iff (rst)
    out_guard_err |-> out_pay_start);
endmodule

bind cfr_framer cfr_framer_chk u_chk (
  .clk(clk), .rst(rst), .lkp_req(lkp_req), .out_valid(out_valid),
  .out_pos(out_pos), .out_hdr_start(out_hdr_start), .out_pay_start(out_pay_start),
  .out_lkp_miss(out_lkp_miss), .out_guard_err(out_guard_err)
);

// File: tb/cfr_framer_tb_top.sv
`timescale 1ns/1ps
module cfr_framer_tb_top;
  localparam int DLY = 12;
  localparam int NE  = 900;
  localparam int AW  = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_byte = '0;
  logic        in_align = 1'b0;
  logic        lkp_req;
  logic [7:0]  lkp_vpi;
  logic [15:0] lkp_vci;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_vpi = '0;
  logic [15:0] rsp_vci = '0;
  logic        out_valid, out_hdr_start, out_pay_start, out_lkp_miss, out_guard_err;
  logic [7:0]  out_byte;
  logic [5:0]  out_pos;

  always #2.5 clk = ~clk;

  cfr_framer #(.DLY(DLY)) dut_i (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_align(in_align),
    .lkp_req(lkp_req), .lkp_vpi(lkp_vpi), .lkp_vci(lkp_vci),
    .rsp_valid(rsp_valid), .rsp_vpi(rsp_vpi), .rsp_vci(rsp_vci),
    .out_valid(out_valid), .out_byte(out_byte), .out_pos(out_pos),
    .out_hdr_start(out_hdr_start), .out_pay_start(out_pay_start),
    .out_lkp_miss(out_lkp_miss), .out_guard_err(out_guard_err)
  );

  logic [7:0]  in_b [AW];
  bit          in_a [AW];
  int          ps   [AW];
  bit          lk   [AW];
  bit          rsp_on [AW];
  logic [7:0]  rvp  [AW];
  logic [15:0] rvc  [AW];
  int checks = 0;
  int fails  = 0;
  int nreq   = 0;
  int nrw    = 0;
  int nmiss  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] b0, b1, b2, b3);
    logic [31:0] s;
    logic [7:0]  c;
    s = {b0, b1, b2, b3};
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ s[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [7:0] gen(input int c, input int p);
    logic [7:0] v;
    if (p <= 5 || (p >= 11 && p <= 15)) begin
      v = 8'hFF;
      if (c == 3 && p == 2)  v = 8'hFE;
      if (c == 5 && p == 13) v = 8'h00;
      if (c == 9 && p == 0)  v = 8'h7F;
    end else if (p <= 10) begin
      v = 8'((c * 29) + (p * 13) + 5);
    end else begin
      v = 8'((c * 7) + p);
    end
    return v;
  endfunction

  function automatic int dly_of(input int q);
    case (q % 6)
      0: return 1;
      1: return DLY - 3;
      2: return DLY - 2;
      3: return 0;
      4: return 5;
      default: return DLY - 3;
    endcase
  endfunction

  task automatic check_edge(input int e);
    int m, p, m6, r;
    bit acc, bad;
    logic [7:0] hb [5];
    logic [7:0] exp_b;
    // R5: request right after the fourth header byte
    chk(lkp_req == (lk[e] && ps[e] == 9), "R5 lkp_req", int'(lkp_req), int'(lk[e] && ps[e] == 9));
    if (lk[e] && ps[e] == 9) begin
      chk(lkp_vpi == {in_b[e-3][3:0], in_b[e-2][7:4]}, "R5 lkp_vpi", int'(lkp_vpi),
          int'({in_b[e-3][3:0], in_b[e-2][7:4]}));
      chk(lkp_vci == {in_b[e-2][3:0], in_b[e-1], in_b[e][7:4]}, "R5 lkp_vci", int'(lkp_vci),
          int'({in_b[e-2][3:0], in_b[e-1], in_b[e][7:4]}));
    end
    m = e - DLY;
    if (m < 1 || !lk[m]) begin
      chk(!out_valid, "R1 out_valid idle", int'(out_valid), 0);
      chk(!out_hdr_start && !out_pay_start && !out_lkp_miss && !out_guard_err,
          "R1 pulses idle", int'({out_hdr_start, out_pay_start, out_lkp_miss, out_guard_err}), 0);
      return;
    end
    p = ps[m];
    chk(out_valid, "R3 out_valid", int'(out_valid), 1);
    chk(int'(out_pos) == p, "R2 out_pos", int'(out_pos), p);
    chk(out_hdr_start == (p == 6), "R4 hdr_start", int'(out_hdr_start), int'(p == 6));
    chk(out_pay_start == (p == 16), "R4 pay_start", int'(out_pay_start), int'(p == 16));
    acc = 1'b0;
    r   = 0;
    if (p >= 6 && p <= 10) begin
      m6 = m - (p - 6);
      for (int x = m6 + 4; x <= m6 + DLY; x++) if (rsp_on[x]) begin acc = 1'b1; r = x; end
    end
    chk(out_lkp_miss == (p == 6 && !acc), "R9 lkp_miss", int'(out_lkp_miss), int'(p == 6 && !acc));
    if (p == 6) begin
      if (acc) nrw++;
      else nmiss++;
    end
    bad = 1'b0;
    if (p == 16)
      for (int x = m - 16; x < m; x++)
        if ((ps[x] <= 5 || (ps[x] >= 11 && ps[x] <= 15)) && in_b[x] != 8'hFF) bad = 1'b1;
    chk(out_guard_err == (p == 16 && bad), "R10 guard_err", int'(out_guard_err), int'(p == 16 && bad));
    exp_b = in_b[m];
    if (acc) begin
      hb[0] = {in_b[m6][7:4], rvp[r][7:4]};
      hb[1] = {rvp[r][3:0], rvc[r][15:12]};
      hb[2] = rvc[r][11:4];
      hb[3] = {rvc[r][3:0], in_b[m6+3][3:0]};
      hb[4] = ref_crc(hb[0], hb[1], hb[2], hb[3]) ^ 8'h55;
      exp_b = hb[p-6];
      if (p == 10) chk(out_byte == exp_b, "R8 hec", int'(out_byte), int'(exp_b));
      else         chk(out_byte == exp_b, "R7 header rewrite", int'(out_byte), int'(exp_b));
    end else if (p >= 6 && p <= 10) begin
      chk(out_byte == exp_b, "R9 header kept", int'(out_byte), int'(exp_b));
    end else begin
      chk(out_byte == exp_b, "R7 passthrough", int'(out_byte), int'(exp_b));
    end
  endtask

  initial begin : wdog
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, NE);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int c, p, cnt;
    bit lock;
    c = 0; p = 0;
    for (int e = 0; e < AW; e++) begin
      rsp_on[e] = 1'b0; rvp[e] = '0; rvc[e] = '0;
      in_b[e] = 8'h3C; in_a[e] = 1'b0;
      if (e >= 11) begin
        in_a[e] = (p == 0);
        in_b[e] = gen(c, p);
        p++;
        if (p == 64 || (c == 7 && p == 4)) begin c++; p = 0; end
      end
    end
    lock = 1'b0; cnt = 0;
    for (int e = 0; e < AW; e++) begin
      if (e >= 1 && in_a[e]) begin ps[e] = 0; lock = 1'b1; end
      else ps[e] = cnt;
      lk[e] = (e >= 1) && lock;
      cnt = (ps[e] + 1) % 64;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !lkp_req, "R1 reset state", int'({out_valid, lkp_req}), 0);
    rst = 1'b0;
    for (int e = 1; e <= NE; e++) begin
      in_byte   = in_b[e];
      in_align  = in_a[e];
      rsp_valid = rsp_on[e];
      rsp_vpi   = rvp[e];
      rsp_vci   = rvc[e];
      @(posedge clk);
      @(negedge clk);
      check_edge(e);
      if (lkp_req) begin
        int d;
        d = dly_of(nreq);
        if (d > 0 && e + d < AW) begin
          rsp_on[e+d] = 1'b1;
          rvp[e+d]    = 8'(8'h40 + nreq);
          rvc[e+d]    = 16'(16'hC000 + nreq * 257);
        end
        nreq++;
      end
    end
    chk(nrw > 0 && nmiss > 0, "R6 window exercised", nrw, nmiss);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule